// File: doc/BRIEF.md
# Infrared SIR Pulse Stretcher

This block sits between an infrared receiver module and a UART receive pin. The receiver delivers a short active-low pulse, nominally 3/16 of a bit wide, for each zero bit. The block detects the falling edge of that pulse and holds its output line low for one full bit time of 16 cycles of the 16x baud clock. A UART sampling near mid-bit then sees an ordinary space. Between pulses the output idles high, which the UART reads as marks.

The input is asynchronous to the clock, so it passes through a synchronizer before edge detection. A second falling edge that arrives while a space is still being stretched restarts the bit timer. Consecutive zero bits therefore produce one unbroken low level. The active-low reset clears the timer and forces the output high. Holding the reset low acts as a receive disable. After reset the edge detector must first see the line high before it accepts a falling edge, so a line stuck low when reset is released does not produce a phantom space.

The output and the input are plain serial levels that are sampled every clock, so neither side has a handshake and no back-pressure applies.

Top module: `sir_rx_stretch`

## Requirements
- R1: While `rst_n` is low, `rcv_o` is high on every cycle, whatever `ir_rx_n` does.
- R2: A high-to-low transition of `ir_rx_n` drives `rcv_o` low on the third rising clock edge, counting as the first the edge that first samples `ir_rx_n` low (two synchronizer flops plus the edge register).
- R3: After a single falling edge, `rcv_o` stays low for exactly `BIT_CYCLES` (default 16) clock cycles and then returns high.
- R4: An `ir_rx_n` that stays low for longer than a bit produces only one space of `BIT_CYCLES` cycles. A low level alone never restarts the timer.
- R5: A falling edge detected while `rcv_o` is low reloads the timer, so `rcv_o` stays low with no gap until `BIT_CYCLES` cycles after the reload.
- R6: The length of the space does not depend on the width of the input pulse. A one-cycle pulse and a three-cycle pulse give the same `BIT_CYCLES`-cycle space, and the rising edge of `ir_rx_n` has no effect.
- R7: If `ir_rx_n` is low when `rst_n` is released, no space is produced until `ir_rx_n` has gone high and then falls again.
- R8: Asserting `rst_n` low during a space drives `rcv_o` high without waiting for a clock edge. After release, `rcv_o` stays high until a new falling edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_16x | input | 1 | Clock at 16 times the baud rate; all logic uses its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; holding it low disables reception |
| ir_rx_n | input | 1 | Active-low pulse from the infrared receiver module, asynchronous |
| rcv_o | output | 1 | Stretched serial line to the UART; idles high, low for a space |

## Verification
The hardest situation to reach is the line already low when reset is released (R7). The bench holds `ir_rx_n` low through a full reset cycle and watches `rcv_o` stay high for many bit times. It then raises the line and drops it again, and expects exactly one space, timed from the second drop. Retriggering (R5) is reached by dropping the input a second time five cycles into an active space. The bench expects one continuous low that ends 16 cycles after the second load. The expected output of every window comes from a per-cycle model in the bench built from R2, R3 and R5.

// File: rtl/sir_rx_pkg.sv
package sir_rx_pkg;
  localparam int unsigned BIT_CYCLES_DEF  = 16;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  // Width of a down-counter that must hold the value n.
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/sir_rx_sync.sv
module sir_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      // Reset value 0: the line counts as "not yet seen high".
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sir_rx_fall_det.sv
module sir_rx_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic fall_o
);
  logic prev_q;

  // prev_q clears to 0 in reset, so an edge is only seen after a high level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line_i;
  end

  assign fall_o = prev_q & ~line_i;
endmodule

// File: rtl/sir_rx_timer.sv
module sir_rx_timer #(
  parameter int unsigned BIT_CYCLES = 16,
  localparam int unsigned CW = sir_rx_pkg::cnt_width(BIT_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  output logic          space_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LOAD_VAL = CW'(BIT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign space_o = (cnt_q != '0);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/sir_rx_stretch.sv
module sir_rx_stretch #(
  parameter int unsigned BIT_CYCLES  = sir_rx_pkg::BIT_CYCLES_DEF,
  parameter int unsigned SYNC_STAGES = sir_rx_pkg::SYNC_STAGES_DEF
) (
  input  logic clk_16x,
  input  logic rst_n,
  input  logic ir_rx_n,
  output logic rcv_o
);
  localparam int unsigned CW = sir_rx_pkg::cnt_width(BIT_CYCLES);

  logic          line_sync;
  logic          fall_evt;
  logic          space;
  logic [CW-1:0] stretch_cnt;

  sir_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk_16x),
    .rst_n (rst_n),
    .d_i   (ir_rx_n),
    .q_o   (line_sync)
  );

  sir_rx_fall_det u_fall (
    .clk    (clk_16x),
    .rst_n  (rst_n),
    .line_i (line_sync),
    .fall_o (fall_evt)
  );

  sir_rx_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
    .clk     (clk_16x),
    .rst_n   (rst_n),
    .load_i  (fall_evt),
    .space_o (space),
    .cnt_o   (stretch_cnt)
  );

  assign rcv_o = ~space;
endmodule

// File: rtl/sir_rx_stretch_chk.sv
module sir_rx_stretch_chk #(
  parameter int unsigned BIT_CYCLES = 16,
  localparam int unsigned CW = sir_rx_pkg::cnt_width(BIT_CYCLES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rcv,
  input logic          fall,
  input logic [CW-1:0] cnt
);
  localparam int unsigned RW = CW + 2;
  logic [RW-1:0] low_run;

  // Consecutive low cycles of rcv, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  low_run <= '0;
    else if (rcv)                low_run <= '0;
    else if (low_run != '1)      low_run <= low_run + 1'b1;
  end

  always @(negedge clk) begin
    if (!rst_n) assert_idle_in_reset_R1: assert (rcv);
  end

  assert_edge_to_space_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !rcv);

  assert_min_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rcv) |-> (low_run >= RW'(BIT_CYCLES)));

  assert_space_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rcv) |-> $past(fall));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (cnt == CW'(BIT_CYCLES)));
endmodule

bind sir_rx_stretch sir_rx_stretch_chk #(.BIT_CYCLES(BIT_CYCLES)) u_chk (
  .clk   (clk_16x),
  .rst_n (rst_n),
  .rcv   (rcv_o),
  .fall  (fall_evt),
  .cnt   (stretch_cnt)
);

// File: tb/sir_rx_stretch_bench.sv
`timescale 1ns/1ps
module sir_rx_stretch_bench;
  localparam int BITC = 16;
  localparam int LAT  = 3;    // sample index offset from drive to first low sample

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_rx_n = 1'b1;
  logic rcv_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sir_rx_stretch u_sir_rx_stretch (
    .clk_16x (clk),
    .rst_n   (rst_n),
    .ir_rx_n (ir_rx_n),
    .rcv_o   (rcv_o)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive in_low[k] at negedge k (after sampling), sample rcv_o at each negedge.
  // prev_low: the line was low before index 0 (no edge at k=0).
  task automatic run_window(input string req, input logic [127:0] in_low,
                            input int n, input bit prev_low);
    logic [127:0] exp_low = '0;
    logic last = prev_low;
    for (int k = 0; k < n; k++) begin
      if (in_low[k] && !last)
        for (int j = k + LAT; j < k + LAT + BITC; j++)
          if (j < 128) exp_low[j] = 1'b1;
      last = in_low[k];
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(req, rcv_o, ~exp_low[k], $sformatf("sample %0d", k));
      ir_rx_n = ~in_low[k];
    end
  endtask

  task automatic t_reset_idle_R1();
    rst_n = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check("R1", rcv_o, 1'b1, "output during reset");
      ir_rx_n = i[1];
    end
    ir_rx_n = 1'b1;
    rst_n = 1'b1;
    idle(6);
    check("R1", rcv_o, 1'b1, "idle after release");
  endtask

  task automatic t_single_R2_R3();
    logic [127:0] p = '0;
    p[0] = 1'b1; p[1] = 1'b1; p[2] = 1'b1;
    run_window("R2/R3 nominal pulse", p, 30, 1'b0);
  endtask

  task automatic t_widths_R6();
    logic [127:0] p = '0;
    p[0] = 1'b1;
    run_window("R6 one-cycle pulse", p, 26, 1'b0);
    p = '0;
    for (int i = 0; i < 10; i++) p[i] = 1'b1;
    run_window("R6 ten-cycle pulse", p, 26, 1'b0);
  endtask

  task automatic t_held_low_R4();
    logic [127:0] p = '0;
    for (int i = 0; i < 60; i++) p[i] = 1'b1;
    run_window("R4 held low", p, 70, 1'b0);
  endtask

  task automatic t_retrigger_R5();
    logic [127:0] p = '0;
    p[0] = 1'b1; p[1] = 1'b1; p[2] = 1'b1;
    p[5] = 1'b1; p[6] = 1'b1; p[7] = 1'b1;
    run_window("R5 retrigger", p, 34, 1'b0);
    p = '0;
    for (int b = 0; b < 4; b++) begin
      p[b*16] = 1'b1; p[b*16+1] = 1'b1; p[b*16+2] = 1'b1;
    end
    run_window("R5 back-to-back zeros", p, 90, 1'b0);
  endtask

  task automatic t_low_at_release_R7();
    logic [127:0] p = '0;
    ir_rx_n = 1'b0;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R7", rcv_o, 1'b1, "line low across release");
    end
    for (int i = 0; i < 4; i++) p[i] = 1'b1;
    for (int i = 8; i < 11; i++) p[i] = 1'b1;
    run_window("R7 first real edge", p, 36, 1'b1);
  endtask

  task automatic t_reset_mid_space_R8();
    @(negedge clk);
    ir_rx_n = 1'b0;
    idle(3);
    ir_rx_n = 1'b1;
    idle(5);
    check("R8", rcv_o, 1'b0, "space active before reset");
    #1 rst_n = 1'b0;
    #1 check("R8", rcv_o, 1'b1, "immediate high on reset");
    idle(2);
    rst_n = 1'b1;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      check("R8", rcv_o, 1'b1, "stays high after release");
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    t_reset_idle_R1();
    t_single_R2_R3();
    idle(4);
    t_widths_R6();
    idle(4);
    t_held_low_R4();
    idle(4);
    t_retrigger_R5();
    idle(4);
    t_low_at_release_R7();
    idle(4);
    t_reset_mid_space_R8();
    idle(4);
    t_single_R2_R3();
    finish_run();
  end
endmodule